// File: doc/BRIEF.md
# Register Dependency Scoreboard with Issue Stall

This block sits between instruction fetch and decode in a small in-order pipeline for 32-bit integer instructions. It guards against read-after-write hazards. For each architectural register it keeps a small count of in-flight instructions that will later write that register. The instruction waiting to issue is checked against these counts. If every register it reads is free, the instruction is granted and passed on. If not, fetch is told to hold, and the downstream stage gets a bubble, which is a cycle whose active flag is clear.

Two operations are recognised: add-immediate and register-register add. Each issue of a recognised instruction raises the count of its destination register. A retire report from the end of the pipeline lowers the count of the register that the retiring instruction wrote. Register 0 is never written, so it is never counted and never blocks anything. A count that reaches zero frees its register one cycle after the retire arrives. Because of this, no write-through register file is needed. Independent instructions flow through back to back.

Top module: `raw_issue_guard`

## Requirements
- R1: A synchronous reset clears every pending count to zero and drives the issued output inactive with an all-zero word; after reset no register blocks issue.
- R2: A word with bits 6:0 = 0010011 and bits 14:12 = 000 is an add-immediate: it reads only the register in bits 19:15 (bits 24:20 are ignored) and writes the register in bits 11:7.
- R3: A word with bits 6:0 = 0110011, bits 14:12 = 000 and bits 31:25 = 0000000 is a register add: it reads the registers in bits 19:15 and 24:20 and waits while either is pending.
- R4: Register 0 is never a hazard source; issuing or retiring with destination 0 never changes any count.
- R5: Each issue of a recognised instruction with a nonzero destination adds one to that register's count; each valid retire with a nonzero register subtracts one; when both hit the same register in one cycle, the count is unchanged.
- R6: A valid recognised instruction with a pending source raises `stall_o`, keeps `issue_go_o` low, and the issued output on the next cycle is inactive (a bubble).
- R7: A retire that arrives in the same cycle as a read of that register still counts as pending; the reader may issue on the following cycle.
- R8: A valid word that is neither recognised form is granted at once without stall, appears as inactive on the next cycle, and changes no count whatever its bits 11:7 hold.
- R9: One cycle after a grant of a recognised instruction, `iss_active_o` is 1 and `iss_instr_o` equals the granted word; otherwise `iss_active_o` is 0 and `iss_instr_o` is zero.
- R10: Each count is 3 bits wide and holds up to 7 pending writers; a count never overflows or goes below zero.
- R11: Instructions with no dependencies between them issue on consecutive cycles without stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Waiting instruction present |
| in_instr | input | 32 | Waiting instruction word |
| ret_valid | input | 1 | A write-carrying instruction retires this cycle |
| ret_rd | input | 5 | Register written by the retiring instruction |
| issue_go_o | output | 1 | Waiting instruction is accepted this cycle |
| stall_o | output | 1 | Fetch must hold its instruction and program counter |
| iss_active_o | output | 1 | Issued output carries a live instruction |
| iss_instr_o | output | 32 | Issued instruction word |

## Verification
The assertions check on every cycle that counts move by exactly one step, or stay put when increment and decrement meet. They also check that counts never wrap in either direction, that register 0 stays at zero, that grant and stall never occur together, and that every stall turns into a bubble. What only the bench scenarios can show is that the right registers are decoded: rs2 blocks a register add but is ignored by add-immediate, and unrecognised words with a live destination field take no count. The scenarios also show that a same-cycle retire still stalls and that clearance arrives exactly one cycle later, all observed through stall and issue at the ports.

// File: rtl/raw_guard_pkg.sv
package raw_guard_pkg;

    localparam int FLD_W = 5;

    localparam logic [6:0] OPC_ARITH_IMM = 7'b0010011;
    localparam logic [6:0] OPC_ARITH_REG = 7'b0110011;
    localparam logic [2:0] SUBOP_SUM     = 3'b000;
    localparam logic [6:0] EXTOP_PLAIN   = 7'b0000000;

    typedef struct packed {
        logic             known;
        logic             reads_b;
        logic [FLD_W-1:0] src_a;
        logic [FLD_W-1:0] src_b;
        logic [FLD_W-1:0] dst;
    } slot_info_t;

endpackage

// File: rtl/raw_guard_decode.sv
module raw_guard_decode
    import raw_guard_pkg::*;
(
    input  logic [31:0] word,
    output slot_info_t  info
);

    logic is_imm;
    logic is_reg;

    always_comb begin
        is_imm = (word[6:0] == OPC_ARITH_IMM) && (word[14:12] == SUBOP_SUM);
        is_reg = (word[6:0] == OPC_ARITH_REG) && (word[14:12] == SUBOP_SUM)
                 && (word[31:25] == EXTOP_PLAIN);

        info.known   = is_imm || is_reg;
        info.reads_b = is_reg;
        info.src_a   = word[19:15];
        info.src_b   = word[24:20];
        info.dst     = word[11:7];
    end

endmodule

// File: rtl/raw_guard_hazard.sv
module raw_guard_hazard
    import raw_guard_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic             valid,
    input  slot_info_t       info,
    input  logic [NREGS-1:0] busy,
    output logic             go,
    output logic             hold
);

    logic hit_a;
    logic hit_b;
    logic blocked;

    always_comb begin
        hit_a   = (info.src_a != '0) && busy[info.src_a];
        hit_b   = info.reads_b && (info.src_b != '0) && busy[info.src_b];
        blocked = info.known && (hit_a || hit_b);
        go      = valid && !blocked;
        hold    = valid && blocked;
    end

endmodule

// File: rtl/raw_guard_cnt_bank.sv
module raw_guard_cnt_bank #(
    parameter int NREGS = 32,
    parameter int CNT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREGS-1:0]            inc_vec,
    input  logic [NREGS-1:0]            dec_vec,
    output logic [NREGS-1:0][CNT_W-1:0] cnt_o,
    output logic [NREGS-1:0]            busy_o
);

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        logic [CNT_W-1:0] cnt_d;
        logic [CNT_W-1:0] cnt_q;

        always_comb begin
            unique case ({inc_vec[g], dec_vec[g]})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
        end

        assign cnt_o[g]  = cnt_q;
        assign busy_o[g] = (cnt_q != '0);
    end

endmodule

// File: rtl/raw_issue_guard.sv
module raw_issue_guard
    import raw_guard_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int CNT_W = 3,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      in_instr,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_rd,
    output logic             issue_go_o,
    output logic             stall_o,
    output logic             iss_active_o,
    output logic [31:0]      iss_instr_o
);

    typedef struct packed {
        logic        act;
        logic [31:0] word;
    } out_state_t;

    slot_info_t                 info;
    logic [NREGS-1:0]           busy_w;
    logic [NREGS-1:0][CNT_W-1:0] cnt_w;
    logic [NREGS-1:0]           inc_vec;
    logic [NREGS-1:0]           dec_vec;
    out_state_t                 st_d;
    out_state_t                 st_q;

    raw_guard_decode u_dec (
        .word (in_instr),
        .info (info)
    );

    raw_guard_hazard #(.NREGS(NREGS)) u_haz (
        .valid (in_valid),
        .info  (info),
        .busy  (busy_w),
        .go    (issue_go_o),
        .hold  (stall_o)
    );

    raw_guard_cnt_bank #(.NREGS(NREGS), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_vec (inc_vec),
        .dec_vec (dec_vec),
        .cnt_o   (cnt_w),
        .busy_o  (busy_w)
    );

    always_comb begin
        inc_vec = '0;
        dec_vec = '0;
        if (issue_go_o && info.known && (info.dst != '0))
            inc_vec[info.dst] = 1'b1;
        if (ret_valid && (ret_rd != '0))
            dec_vec[ret_rd] = 1'b1;

        st_d.act  = issue_go_o && info.known;
        st_d.word = st_d.act ? in_instr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign iss_active_o = st_q.act;
    assign iss_instr_o  = st_q.word;

endmodule

// File: rtl/raw_guard_chk.sv
module raw_guard_chk #(
    parameter int NREGS = 32,
    parameter int CNT_W = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        issue_go,
    input logic                        stall,
    input logic                        iss_active,
    input logic [NREGS-1:0]            inc_vec,
    input logic [NREGS-1:0]            dec_vec,
    input logic [NREGS-1:0][CNT_W-1:0] cnt
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // R10
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (inc_vec[g] && !dec_vec[g]) |-> (cnt[g] != '1));
        // R10
        no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_vec[g] && !inc_vec[g]) |-> (cnt[g] != '0));
        // R5
        count_up_chk: assert property (@(posedge clk) disable iff (rst)
            (inc_vec[g] && !dec_vec[g]) |=> (cnt[g] == $past(cnt[g]) + 1'b1));
        // R5
        count_down_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_vec[g] && !inc_vec[g]) |=> (cnt[g] == $past(cnt[g]) - 1'b1));
        // R5
        count_meet_chk: assert property (@(posedge clk) disable iff (rst)
            (inc_vec[g] && dec_vec[g]) |=> $stable(cnt[g]));
    end

    // R4
    zero_reg_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[0] == '0);
    // R6
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue_go && stall));
    // R6
    bubble_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !iss_active);
    // R9
    active_from_grant_chk: assert property (@(posedge clk) disable iff (rst)
        iss_active |-> $past(issue_go));

endmodule

bind raw_issue_guard raw_guard_chk #(.NREGS(NREGS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_go   (issue_go_o),
    .stall      (stall_o),
    .iss_active (iss_active_o),
    .inc_vec    (inc_vec),
    .dec_vec    (dec_vec),
    .cnt        (cnt_w)
);

// File: tb/test_raw_issue_guard.sv
`timescale 1ns/1ps
module test_raw_issue_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic        ret_valid;
    logic [4:0]  ret_rd;
    logic        issue_go_o;
    logic        stall_o;
    logic        iss_active_o;
    logic [31:0] iss_instr_o;

    always #2 clk = ~clk;

    raw_issue_guard i_raw_issue_guard (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_instr     (in_instr),
        .ret_valid    (ret_valid),
        .ret_rd       (ret_rd),
        .issue_go_o   (issue_go_o),
        .stall_o      (stall_o),
        .iss_active_o (iss_active_o),
        .iss_instr_o  (iss_instr_o)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          mdl[32];
    logic        exp_act = 1'b0;
    logic [31:0] exp_word = '0;
    bit          done = 1'b0;

    function automatic logic [31:0] addi(logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
        return {imm, rs1, 3'b000, rd, 7'b0010011};
    endfunction

    function automatic logic [31:0] addr(logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
        return {7'b0000000, rs2, rs1, 3'b000, rd, 7'b0110011};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit v, logic [31:0] w, bit rv, logic [4:0] rr, string tag);
        bit k, ub, blk, eg, es;
        logic [4:0] a, b, d;
        @(negedge clk);
        chk(tag, "issued active", {31'b0, iss_active_o}, {31'b0, exp_act});
        chk(tag, "issued word", iss_instr_o, exp_word);
        in_valid  = v;
        in_instr  = w;
        ret_valid = rv;
        ret_rd    = rr;
        #1;
        ub  = (w[6:0] == 7'b0110011) && (w[14:12] == 3'b000) && (w[31:25] == 7'b0);
        k   = ub || ((w[6:0] == 7'b0010011) && (w[14:12] == 3'b000));
        a   = w[19:15];
        b   = w[24:20];
        d   = w[11:7];
        blk = k && ((a != 0 && mdl[a] != 0) || (ub && b != 0 && mdl[b] != 0));
        eg  = v && !blk;
        es  = v && blk;
        chk(tag, "grant", {31'b0, issue_go_o}, {31'b0, eg});
        chk(tag, "stall", {31'b0, stall_o}, {31'b0, es});
        exp_act  = eg && k;
        exp_word = exp_act ? w : 32'h0;
        if (exp_act && d != 0) mdl[d]++;
        if (rv && rr != 0) mdl[rr]--;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        foreach (mdl[i]) mdl[i] = 0;
        rst = 1'b1; in_valid = 1'b0; in_instr = '0; ret_valid = 1'b0; ret_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of the issued output
        chk("R1", "active after reset", {31'b0, iss_active_o}, 32'h0);
        chk("R1", "word after reset", iss_instr_o, 32'h0);

        // R1: no register pending after reset (sweep every source pair)
        for (int r = 1; r < 32; r++) cyc(1, addr(5'd0, 5'(r), 5'(r)), 0, 0, "R1");

        // R2 / R6 / R7: per-register writer then reader, retire collides with read
        for (int r = 1; r < 32; r++) begin
            cyc(1, addi(5'(r), 5'd0, 12'd5), 0, 0, "R2");
            cyc(1, addi(5'd0, 5'(r), 12'd1), 0, 0, "R6");
            cyc(1, addi(5'd0, 5'(r), 12'd1), 1, 5'(r), "R7");
            cyc(1, addi(5'd0, 5'(r), 12'd1), 0, 0, "R7");
        end

        // R3: register add waits on its second source
        for (int r = 1; r < 32; r++) begin
            cyc(1, addi(5'(r), 5'd0, 12'd1), 0, 0, "R3");
            cyc(1, addr(5'd0, 5'd0, 5'(r)), 0, 0, "R3");
            cyc(1, addr(5'd0, 5'd0, 5'(r)), 1, 5'(r), "R3");
            cyc(1, addr(5'd0, 5'd0, 5'(r)), 0, 0, "R3");
        end

        // R2: add-immediate ignores bits 24:20 even when they name a pending register
        cyc(1, addi(5'd4, 5'd0, 12'd0), 0, 0, "R2");
        cyc(1, addi(5'd0, 5'd1, 12'd4), 0, 0, "R2");
        cyc(0, 32'h0, 1, 5'd4, "R2");

        // R10 / R5: fill one register to 7 writers, drain one by one
        for (int n = 0; n < 7; n++) cyc(1, addi(5'd5, 5'd0, 12'(n)), 0, 0, "R10");
        for (int n = 0; n < 7; n++) cyc(1, addi(5'd0, 5'd5, 12'd0), 1, 5'd5, "R5");
        cyc(1, addi(5'd0, 5'd5, 12'd0), 0, 0, "R5");

        // R5: increment and decrement on one register in the same cycle
        cyc(1, addi(5'd6, 5'd0, 12'd1), 0, 0, "R5");
        cyc(1, addi(5'd6, 5'd0, 12'd2), 1, 5'd6, "R5");
        cyc(1, addi(5'd0, 5'd6, 12'd0), 0, 0, "R5");
        cyc(1, addi(5'd0, 5'd6, 12'd0), 1, 5'd6, "R5");
        cyc(1, addi(5'd0, 5'd6, 12'd0), 0, 0, "R5");

        // R4: destination 0 and retire of register 0 leave everything free
        cyc(1, addi(5'd0, 5'd0, 12'd9), 1, 5'd0, "R4");
        cyc(1, addr(5'd0, 5'd0, 5'd0), 1, 5'd0, "R4");
        cyc(1, addi(5'd0, 5'd0, 12'd0), 0, 0, "R4");

        // R8: unrecognised words pass as inactive and take no count
        cyc(1, {7'b0100000, 5'd0, 5'd0, 3'b000, 5'd7, 7'b0110011}, 0, 0, "R8");
        cyc(1, {12'd0, 5'd7, 3'b001, 5'd7, 7'b0010011}, 0, 0, "R8");
        cyc(1, 32'h0000_0F83, 0, 0, "R8");
        cyc(1, addi(5'd0, 5'd7, 12'd0), 0, 0, "R8");
        cyc(1, addi(5'd0, 5'd31, 12'd0), 0, 0, "R8");

        // R11 / R9: independent instructions back to back, then drain
        cyc(1, addi(5'd1, 5'd0, 12'd1), 0, 0, "R11");
        cyc(1, addi(5'd2, 5'd0, 12'd2), 0, 0, "R11");
        cyc(1, addr(5'd3, 5'd8, 5'd9), 0, 0, "R11");
        cyc(1, addi(5'd10, 5'd11, 12'd3), 1, 5'd1, "R9");
        cyc(0, 32'h0, 1, 5'd2, "R9");
        cyc(0, 32'h0, 1, 5'd3, "R9");
        cyc(0, 32'h0, 1, 5'd10, "R9");
        cyc(1, addr(5'd0, 5'd1, 5'd2), 0, 0, "R11");
        cyc(1, addr(5'd0, 5'd3, 5'd10), 0, 0, "R11");
        cyc(0, 32'h0, 0, 0, "R9");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule